// File: doc/BRIEF.md
# Digital Frequency Synthesizer Core

This block holds the digital half of a phase-locked frequency synthesizer. It runs on the reference clock and divides it down to a fixed comparison rate. The divide ratio is one of two values, picked by a step-select pin. A second input carries the feedback signal, which has already been mixed down to a digital rate. Its rising edges are counted through a divide-by-N counter. N is a 9-bit binary word taken straight from parallel program pins.

A dual flip-flop phase-frequency detector compares the two divided event streams and drives pump-up or pump-down pulses toward an external loop filter. Each pulse lasts for the distance between the two events, counted in reference clocks. A lock monitor watches the pulse width in every comparison period and raises a lock flag once the loop has stayed tight long enough.

Top module: `freq_synth_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the first cycle after it is released, `pump_up`, `pump_dn` and `locked` are 0.
- R2: With `step_fine` = 1, a reference comparison event falls on every `REF_DIV_FINE`-th clock (default 1024), the first one in cycle `REF_DIV_FINE`-1, where cycle 0 is the first cycle after reset release.
- R3: With `step_fine` = 0, the reference event spacing is `REF_DIV_COARSE` clocks (default 2048). The ratio is captured at reset and at each reference event.
- R4: `n_word` bit i carries weight 2^i, so N is the unsigned value of the word (at most 511). A rising level on `fb_clk` that is first sampled at clock edge k counts as a feedback edge in the cycle ending at edge k+2. Every N-th feedback edge is a feedback comparison event.
- R5: A new `n_word` is taken only at the feedback event that ends the current period, so a period already in progress runs to its full old length.
- R6: When a reference event comes d cycles before a feedback event, `pump_up` is high for exactly d cycles, starting the cycle after the reference event.
- R7: When a feedback event comes d cycles before a reference event, `pump_dn` is high for exactly d cycles.
- R8: Coincident events produce no pulse, and `pump_up` and `pump_dn` are never high together.
- R9: `locked` rises in the cycle after the 8th consecutive reference event at which the pump-high time of the period just ended was at most 2 cycles.
- R10: `locked` falls in the cycle after the first reference event whose period had more than 2 pump-high cycles.
- R11: An N of 0 or 1 is invalid. From the cycle after it is loaded, no feedback events occur and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_fine | input | 1 | 1 selects the fine comparison step, 0 the coarse one |
| fb_clk | input | 1 | Downmixed feedback signal, sampled asynchronously |
| n_word | input | N_BITS | Feedback modulus N, binary, LSB weight 1 |
| pump_up | output | 1 | Correction request: raise the oscillator frequency |
| pump_dn | output | 1 | Correction request: lower the oscillator frequency |
| locked | output | 1 | High while the loop is judged locked |

## Verification
A reference or feedback counter that runs on the wrong count shifts its event by whole cycles. Within one comparison period this shows at the ports as a pump pulse of the wrong width or of the wrong polarity. A modulus loaded too early shortens a feedback period, and the missing pulse is visible within the next two periods. Faults in the lock monitor move the rise or fall of `locked` off its exact cycle: the 8th good event, or the first bad event. The bench therefore pins these edges to single cycles, and it measures pulse widths over whole windows of several periods.

// File: rtl/synth_pkg.sv
package synth_pkg;

  // Terminal count of the reference divider for the selected step.
  function automatic int ref_last(input logic fine, input int div_fine, input int div_coarse);
    return (fine ? div_fine : div_coarse) - 1;
  endfunction

  // A feedback modulus below two cannot form a period.
  function automatic bit modulus_ok(input int unsigned n);
    return n >= 2;
  endfunction

  // One comparison period is tight when its pump-high time is within tolerance.
  function automatic bit width_ok(input int width, input int tol);
    return width <= tol;
  endfunction

endpackage

// File: rtl/sd_ref_divider.sv
module sd_ref_divider #(
  parameter int DIV_FINE   = 1024,
  parameter int DIV_COARSE = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_fine,
  output logic ref_tick
);
  import synth_pkg::*;

  localparam int DMAX = (DIV_FINE > DIV_COARSE) ? DIV_FINE : DIV_COARSE;
  localparam int CW   = $clog2(DMAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;

  always_comb ref_tick = (cnt_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= CW'(ref_last(step_fine, DIV_FINE, DIV_COARSE));
    end else if (ref_tick) begin
      cnt_q  <= '0;
      last_q <= CW'(ref_last(step_fine, DIV_FINE, DIV_COARSE));
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q);

  // R3
  step_at_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_q) |-> $past(ref_tick));

endmodule

// File: rtl/sd_fb_divider.sv
module sd_fb_divider #(
  parameter int N_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fb_clk,
  input  logic [N_BITS-1:0] n_word,
  output logic              fb_tick,
  output logic              n_bad
);
  import synth_pkg::*;

  logic              s1_q, s2_q, s3_q;
  logic              fb_edge;
  logic [N_BITS-1:0] n_q;
  logic [N_BITS-1:0] cnt_q;

  always_comb begin
    fb_edge = s2_q & ~s3_q;
    n_bad   = !modulus_ok(int'(n_q));
    fb_tick = fb_edge & ~n_bad & (cnt_q == n_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cnt_q <= '0;
      n_q   <= n_word;
    end else begin
      s1_q <= fb_clk;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (n_bad || fb_tick) begin
        cnt_q <= '0;
        n_q   <= n_word;
      end else if (fb_edge) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  modulus_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_q) |-> $past(n_bad || fb_tick));

  // R4
  count_below_modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !n_bad |-> cnt_q < n_q);

endmodule

// File: rtl/sd_phase_detector.sv
module sd_phase_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic up_q,
  output logic dn_q
);
  logic up_set, dn_set;

  always_comb begin
    up_set = up_q | ref_tick;
    dn_set = dn_q | fb_tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (up_set && dn_set)) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set;
      dn_q <= dn_set;
    end
  end

  // R6
  up_starts_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_tick));

  // R6
  up_ends_on_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_q) |-> $past(fb_tick));

  // R7
  dn_starts_on_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(fb_tick));

  // R7
  dn_ends_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_q) |-> $past(ref_tick));

endmodule

// File: rtl/sd_lock_monitor.sv
module sd_lock_monitor #(
  parameter int LOCK_PERIODS = 8,
  parameter int LOCK_TOL     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic pump,
  input  logic n_bad,
  output logic locked
);
  import synth_pkg::*;

  localparam int WW = $clog2(LOCK_TOL + 2) + 1;
  localparam int GW = $clog2(LOCK_PERIODS + 1);
  localparam logic [WW-1:0] WSAT = WW'(LOCK_TOL + 1);
  localparam logic [GW-1:0] GFULL = GW'(LOCK_PERIODS);

  logic [WW-1:0] wd_q;
  logic [GW-1:0] gc_q;
  logic          good;

  always_comb begin
    good   = width_ok(int'(wd_q) + int'(pump), LOCK_TOL);
    locked = (gc_q == GFULL) & ~n_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_q <= '0;
      gc_q <= '0;
    end else begin
      if (ref_tick)                 wd_q <= '0;
      else if (pump && wd_q != WSAT) wd_q <= wd_q + 1'b1;

      if (n_bad)                    gc_q <= '0;
      else if (ref_tick && !good)   gc_q <= '0;
      else if (ref_tick && gc_q != GFULL) gc_q <= gc_q + 1'b1;
    end
  end

  // R9
  lock_rises_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_tick));

  // R10
  lock_drops_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !good) |=> !locked);

endmodule

// File: rtl/freq_synth_core.sv
module freq_synth_core #(
  parameter int REF_DIV_FINE   = 1024,
  parameter int REF_DIV_COARSE = 2048,
  parameter int N_BITS         = 9,
  parameter int LOCK_PERIODS   = 8,
  parameter int LOCK_TOL       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_fine,
  input  logic              fb_clk,
  input  logic [N_BITS-1:0] n_word,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              locked
);
  logic ref_evt;
  logic fb_evt;
  logic n_invalid;

  sd_ref_divider #(.DIV_FINE(REF_DIV_FINE), .DIV_COARSE(REF_DIV_COARSE)) u_ref (
    .clk(clk), .rst_n(rst_n), .step_fine(step_fine), .ref_tick(ref_evt));

  sd_fb_divider #(.N_BITS(N_BITS)) u_fb (
    .clk(clk), .rst_n(rst_n), .fb_clk(fb_clk), .n_word(n_word),
    .fb_tick(fb_evt), .n_bad(n_invalid));

  sd_phase_detector u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_evt), .fb_tick(fb_evt),
    .up_q(pump_up), .dn_q(pump_dn));

  sd_lock_monitor #(.LOCK_PERIODS(LOCK_PERIODS), .LOCK_TOL(LOCK_TOL)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_evt), .pump(pump_up | pump_dn),
    .n_bad(n_invalid), .locked(locked));

  // R11
  invalid_no_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_invalid |-> !fb_evt && !locked);

  // R8
  pumps_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

endmodule

// File: tb/freq_synth_core_test.sv
`timescale 1ns/1ps
module freq_synth_core_test;
  localparam int RF = 24;
  localparam int RC = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_fine = 1'b1;
  logic       fb_clk = 1'b0;
  logic [8:0] n_word = 9'd3;
  wire        pump_up, pump_dn, locked;

  int ecount = 0;
  int checks = 0;
  int errors = 0;
  int fb_start = 1;
  int fb_per = 8;
  int nu, nd, nb, nl;

  freq_synth_core #(.REF_DIV_FINE(RF), .REF_DIV_COARSE(RC)) uut (
    .clk(clk), .rst_n(rst_n), .step_fine(step_fine), .fb_clk(fb_clk),
    .n_word(n_word), .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked));

  always #2 clk = ~clk;

  // ecount at a negedge = index of the cycle now running (0 = first after reset)
  always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

  // feedback square wave: rises at the negedge of cycle fb_start + i*fb_per
  always @(negedge clk)
    fb_clk <= (ecount >= fb_start) && (((ecount - fb_start) % fb_per) < fb_per / 2);

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): cycles actual 150000 expected fewer");
    summary();
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, ecount);
    end
  endtask

  task automatic do_reset(input logic stp, input int n, input int st, input int per);
    @(negedge clk);
    rst_n = 1'b0;
    step_fine = stp;
    n_word = 9'(n);
    fb_start = st;
    fb_per = per;
    repeat (3) @(negedge clk);
    check("R1 reset up", int'(pump_up), 0);
    check("R1 reset dn", int'(pump_dn), 0);
    check("R1 reset locked", int'(locked), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_to(input int k);
    while (ecount < k) @(negedge clk);
  endtask

  task automatic tally(input int a, input int b, output int u, output int d,
                       output int both, output int l);
    u = 0; d = 0; both = 0; l = 0;
    wait_to(a);
    for (int k = a; k <= b; k++) begin
      if (k > a) @(negedge clk);
      u += int'(pump_up);
      d += int'(pump_dn);
      both += int'(pump_up & pump_dn);
      l += int'(locked);
    end
  endtask

  initial begin
    // Fine step, N=3, feedback period 8: event spacing 24 matches the reference.
    // Phase offset d (cycles from reference event to feedback event).
    for (int d = -4; d <= 4; d++) begin
      do_reset(1'b1, 3, 5 + d, 8);
      wait_to(0);
      check("R1 first cycle up", int'(pump_up), 0);
      check("R1 first cycle locked", int'(locked), 0);
      tally(10 * RF, 14 * RF - 1, nu, nd, nb, nl);
      check("R6 up width x4", nu, d > 0 ? 4 * d : 0);
      check("R7 dn width x4", nd, d < 0 ? -4 * d : 0);
      check("R8 both high", nb, 0);
      wait_to(16 * RF);
      if (d >= -2 && d <= 2) check("R9 lock within tolerance", int'(locked), 1);
      else check("R10 no lock beyond tolerance", int'(locked), 0);
    end

    // R2 R9: exact lock edge with coincident events (ref events at 23+24m)
    do_reset(1'b1, 3, 5, 8);
    wait_to(191);
    check("R9 locked before 8th good event", int'(locked), 0);
    wait_to(192);
    check("R9 locked after 8th good event", int'(locked), 1);
    // R4 R5: change N to 6 (bits 1 and 2) just after the event at cycle 263
    wait_to(264);
    n_word = 9'd6;
    tally(264, 287, nu, nd, nb, nl);
    check("R5 old period completes, no pulse", nu + nd, 0);
    tally(288, 335, nu, nd, nb, nl);
    check("R4 N=6 doubles feedback period, up width", nu, 24);
    check("R4 dn stays low", nd, 0);
    check("R10 locked through last good event", int'(locked), 1);
    wait_to(336);
    check("R10 locked drops after first bad period", int'(locked), 0);

    // R11: invalid N loaded at the feedback event of cycle 287
    do_reset(1'b1, 3, 5, 8);
    wait_to(264);
    n_word = 9'd1;
    wait_to(287);
    check("R11 locked before invalid load", int'(locked), 1);
    wait_to(288);
    check("R11 locked cleared by invalid N", int'(locked), 0);
    tally(290, 500, nu, nd, nb, nl);
    check("R11 no feedback events with N=1", nd, 0);
    check("R11 locked stays low", nl, 0);

    // R11: N=0 from reset
    do_reset(1'b1, 0, 5, 8);
    tally(10, 600, nu, nd, nb, nl);
    check("R11 no feedback events with N=0", nd, 0);
    check("R11 never locked with N=0", nl, 0);

    // R3: coarse step, N=6 period 8 matches spacing 48; ref events at 47+48m
    do_reset(1'b0, 6, 5, 8);
    wait_to(383);
    check("R3 coarse locked before 8th event", int'(locked), 0);
    wait_to(384);
    check("R3 coarse locked after 8th event", int'(locked), 1);

    do_reset(1'b0, 6, 7, 8);
    tally(10 * RC, 14 * RC - 1, nu, nd, nb, nl);
    check("R3 coarse up width x4", nu, 8);
    check("R3 coarse dn", nd, 0);

    // R3: coarse step with feedback at the fine rate never locks
    do_reset(1'b0, 3, 5, 8);
    tally(10 * RC, 20 * RC - 1, nu, nd, nb, nl);
    check("R3 fast feedback gives dn pulses", int'(nd > 0), 1);
    check("R3 fast feedback never locked", nl, 0);

    // R2: fine step with feedback at the coarse rate never locks
    do_reset(1'b1, 6, 5, 8);
    tally(10 * RF, 30 * RF - 1, nu, nd, nb, nl);
    check("R2 slow feedback gives up pulses", int'(nu > 0), 1);
    check("R2 slow feedback never locked", nl, 0);
    check("R8 both high under mismatch", nb, 0);

    summary();
    $finish;
  end
endmodule